// File: doc/BRIEF.md
# Packed Pixel Unpacker with YUV Matrix

This block sits between a fetch FIFO and a display pipeline. It accepts 32-bit words holding packed pixel data on a valid/ready input and emits one pixel per beat on a valid/ready output. Each output pixel carries 8-bit red, green, blue and alpha. A 3-bit format code selects how the bytes are interpreted. Byte 0 of every word (bits [7:0]) is the oldest byte in memory order. A swap input exchanges the outer components, so a single code serves both RGB and BGR orderings.

For the two 4:2:2 luma/chroma formats, a fixed BT.601 matrix can convert each pixel to RGB. The matrix uses Q8 integer coefficients and clamps the result. It acts only when the enable is set and the matrix select equals 6. With the matrix off, 4:2:2 components pass straight through. Every RGB format ignores the matrix controls.

The format, swap and matrix controls are sampled every cycle. They must stay constant while any byte of a stream is held inside the block.

Top module: `pix_unpack`

## Requirements
- R1: After reset, pix_valid_o is 0 and word_ready_o is 1.
- R2: Code 0 (16-bit 5:6:5): each word yields two pixels, and the low half-word is taken first. Red is bits [15:11], green [10:5], blue [4:0]. Each field is widened to 8 bits by copying its top bits into the vacated low bits.
- R3: Code 1 (24-bit): three words yield four pixels, and a pixel's bytes may straddle a word boundary. Taking the pixel's bytes in memory order, the first byte is blue, the second green and the third red.
- R4: Code 2 (32-bit, alpha last): the pixel is one word, with red in [31:24], green in [23:16], blue in [15:8] and alpha in [7:0].
- R5: Code 3 (32-bit, alpha first): the pixel is one word, with alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0].
- R6: With swap_i set, red and blue are exchanged for the RGB codes, and the two chroma samples are exchanged for the 4:2:2 codes.
- R7: Code 4 (4:2:2, byte order U Y0 V Y1): each word yields two pixels that share its U and V samples. With the matrix inactive, the output is R=V, G=Y and B=U.
- R8: Code 5 (4:2:2, byte order Y0 U Y1 V): the pixel pairing is the same as in R7, and the bypass mapping is R=V, G=Y, B=U.
- R9: For codes 4 and 5, the matrix is active when mtx_en_i is 1 and mtx_sel_i is 6. In that case, with C=Y-16, D=U-128 and E=V-128, the outputs are:
  - R=(298C+409E+128)>>8
  - G=(298C-100D-208E+128)>>8
  - B=(298C+516D+128)>>8

  Each result uses an arithmetic shift and is clamped to 0..255. Any other mtx_sel_i value gives the bypass mapping.
- R10: For codes 0 to 3 and 6 to 7, mtx_en_i and mtx_sel_i have no effect on the output.
- R11: Alpha is 0xFF for every code except 2 and 3.
- R12: While pix_valid_o=1 and pix_ready_i=0, the output pixel and valid hold. No pixel is lost or duplicated under any stall pattern.
- R13: Codes 6 and 7 decode exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Packed format code |
| swap_i | input | 1 | Component order swap |
| mtx_en_i | input | 1 | Colour matrix enable |
| mtx_sel_i | input | 4 | Matrix select, 6 = BT.601 YUV to RGB |
| word_valid_i | input | 1 | Input word valid |
| word_i | input | 32 | Input word, byte 0 oldest |
| word_ready_o | output | 1 | Input word accepted when high with valid |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Downstream ready |
| pix_r_o | output | 8 | Red |
| pix_g_o | output | 8 | Green |
| pix_b_o | output | 8 | Blue |
| pix_a_o | output | 8 | Alpha |

## Verification
Each targeted corner case is listed below with the failure it catches.

- **24-bit word straddling:** the 24-bit stream is fed as full three-word groups. A buffer that dropped or reordered straddling bytes would corrupt the second and third pixels of each group.
- **4:2:2 pairing:** both pixels of each pair are compared. A design that advanced the word after the first pixel, or took luma from the wrong byte, would mismatch on every second pixel.
- **Matrix corners:** the matrix inputs include limits that drive results below 0 and above 255. A missing or wrap-around clamp would show up as wildly wrong bytes.
- **Matrix controls on RGB:** the matrix controls are also set during RGB traffic, to catch a matrix that leaks into RGB formats.
- **Backpressure:** a periodic stall pattern on pix_ready_i exposes lost or repeated pixels at the output register.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W     = 32;
  localparam int COMP_W     = 8;
  localparam int FMT_W      = 3;
  localparam int SEL_W      = 4;
  localparam int WORD_BYTES = WORD_W / 8;

  localparam logic [FMT_W-1:0] FMT_P16  = 3'd0;
  localparam logic [FMT_W-1:0] FMT_P24  = 3'd1;
  localparam logic [FMT_W-1:0] FMT_P32A = 3'd2;
  localparam logic [FMT_W-1:0] FMT_P32B = 3'd3;
  localparam logic [FMT_W-1:0] FMT_UYVY = 3'd4;
  localparam logic [FMT_W-1:0] FMT_YUYV = 3'd5;
  localparam logic [SEL_W-1:0] MTX_BT601 = 4'd6;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
    logic [COMP_W-1:0] a;
  } pix_t;

  function automatic logic is_yuv(input logic [FMT_W-1:0] f);
    return (f == FMT_UYVY) || (f == FMT_YUYV);
  endfunction

  // bytes a pixel occupies before it can be emitted
  function automatic logic [3:0] need_bytes(input logic [FMT_W-1:0] f);
    case (f)
      FMT_P24:                               return 4'd3;
      FMT_P32A, FMT_P32B, FMT_UYVY, FMT_YUYV: return 4'd4;
      default:                               return 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/pix_byte_buf.sv
module pix_byte_buf
  import pix_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  input  logic              take_i,
  output logic              avail_o,
  output logic [WORD_W-1:0] bytes_o,
  output logic              phase_o
);
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(2 * WORD_BYTES + 1);
  localparam logic [CNT_W-1:0] WB = CNT_W'(WORD_BYTES);

  logic [BUF_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cons, rem, need;
  logic             phase_q, phase_d, push, pop;

  assign need         = CNT_W'(need_bytes(fmt_i));
  assign avail_o      = cnt_q >= need;
  assign word_ready_o = cnt_q <= WB;
  assign push         = word_valid_i && word_ready_o;
  assign pop          = take_i && avail_o;
  assign bytes_o      = buf_q[WORD_W-1:0];
  assign phase_o      = phase_q;

  always_comb begin
    cons    = '0;
    phase_d = phase_q;
    if (pop) begin
      if (is_yuv(fmt_i)) begin
        // first pixel of a 4:2:2 pair keeps the word
        cons    = phase_q ? need : '0;
        phase_d = ~phase_q;
      end else begin
        cons = need;
      end
    end
    rem   = cnt_q - cons;
    buf_d = buf_q >> {cons, 3'b000};
    if (push) buf_d = buf_d | ({{WORD_W{1'b0}}, word_i} << {rem, 3'b000});
    cnt_d = rem + (push ? WB : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/pix_fmt_decode.sv
module pix_fmt_decode
  import pix_unpack_pkg::*;
(
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic              swap_i,
  input  logic              phase_i,
  input  logic [WORD_W-1:0] bytes_i,
  output pix_t              pix_o,
  output logic [COMP_W-1:0] y_o,
  output logic [COMP_W-1:0] u_o,
  output logic [COMP_W-1:0] v_o
);
  logic [COMP_W-1:0] b0, b1, b2, b3, cr, cb, uu, vv;
  logic [4:0] r5, bl5;

  assign {b3, b2, b1, b0} = bytes_i;

  always_comb begin
    pix_o = '{r: 8'h00, g: 8'h00, b: 8'h00, a: 8'hFF};
    uu = '0; vv = '0; y_o = '0;
    r5 = '0; bl5 = '0; cr = '0; cb = '0;
    case (fmt_i)
      FMT_P24: begin
        cr = b2; cb = b0; pix_o.g = b1;
      end
      FMT_P32A: begin
        cr = b3; pix_o.g = b2; cb = b1; pix_o.a = b0;
      end
      FMT_P32B: begin
        pix_o.a = b3; cr = b2; pix_o.g = b1; cb = b0;
      end
      FMT_UYVY: begin
        uu = b0; vv = b2; y_o = phase_i ? b3 : b1;
      end
      FMT_YUYV: begin
        uu = b1; vv = b3; y_o = phase_i ? b2 : b0;
      end
      default: begin
        r5  = b1[7:3];
        bl5 = b0[4:0];
        pix_o.g = {b1[2:0], b0[7:5], b1[2:1]};
        cr = {r5, r5[4:2]};
        cb = {bl5, bl5[4:2]};
      end
    endcase
    if (swap_i) begin
      pix_o.r = cb; pix_o.b = cr;
      u_o = vv; v_o = uu;
    end else begin
      pix_o.r = cr; pix_o.b = cb;
      u_o = uu; v_o = vv;
    end
    if (is_yuv(fmt_i)) begin
      pix_o.r = v_o; pix_o.g = y_o; pix_o.b = u_o;
    end
  end
endmodule

// File: rtl/pix_yuv_mtx.sv
module pix_yuv_mtx
  import pix_unpack_pkg::*;
(
  input  logic [COMP_W-1:0] y_i,
  input  logic [COMP_W-1:0] u_i,
  input  logic [COMP_W-1:0] v_i,
  output pix_t              pix_o
);
  localparam int ACC_W = 20;

  function automatic logic [COMP_W-1:0] clamp(input logic signed [ACC_W-1:0] x);
    logic signed [ACC_W-1:0] s;
    s = x >>> 8;
    if (s < 0)                  return '0;
    else if (s > ACC_W'(255))   return '1;
    else                        return s[COMP_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] c, d, e, rs, gs, bs;

  always_comb begin
    c  = $signed({{(ACC_W-COMP_W){1'b0}}, y_i}) - 20'sd16;
    d  = $signed({{(ACC_W-COMP_W){1'b0}}, u_i}) - 20'sd128;
    e  = $signed({{(ACC_W-COMP_W){1'b0}}, v_i}) - 20'sd128;
    rs = 20'sd298 * c + 20'sd409 * e + 20'sd128;
    gs = 20'sd298 * c - 20'sd100 * d - 20'sd208 * e + 20'sd128;
    bs = 20'sd298 * c + 20'sd516 * d + 20'sd128;
    pix_o.r = clamp(rs);
    pix_o.g = clamp(gs);
    pix_o.b = clamp(bs);
    pix_o.a = '1;
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic              swap_i,
  input  logic              mtx_en_i,
  input  logic [3:0]        mtx_sel_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [7:0]        pix_r_o,
  output logic [7:0]        pix_g_o,
  output logic [7:0]        pix_b_o,
  output logic [7:0]        pix_a_o
);
  logic              load, avail, phase, use_mtx;
  logic [WORD_W-1:0] bytes;
  logic [COMP_W-1:0] y, u, v;
  pix_t              dec_pix, mtx_pix, pix_q;
  logic              valid_q;

  assign load = !valid_q || pix_ready_i;

  pix_byte_buf u_buf (
    .clk_i, .rst_ni, .fmt_i, .word_valid_i, .word_i, .word_ready_o,
    .take_i(load), .avail_o(avail), .bytes_o(bytes), .phase_o(phase)
  );

  pix_fmt_decode u_dec (
    .fmt_i, .swap_i, .phase_i(phase), .bytes_i(bytes),
    .pix_o(dec_pix), .y_o(y), .u_o(u), .v_o(v)
  );

  pix_yuv_mtx u_mtx (.y_i(y), .u_i(u), .v_i(v), .pix_o(mtx_pix));

  assign use_mtx = is_yuv(fmt_i) && mtx_en_i && (mtx_sel_i == MTX_BT601);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else if (load) begin
      valid_q <= avail;
      if (avail) pix_q <= use_mtx ? mtx_pix : dec_pix;
    end
  end

  assign pix_valid_o = valid_q;
  assign pix_r_o     = pix_q.r;
  assign pix_g_o     = pix_q.g;
  assign pix_b_o     = pix_q.b;
  assign pix_a_o     = pix_q.a;
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] fmt_i,
  input logic       pix_valid_o,
  input logic       pix_ready_i,
  input logic [7:0] pix_r_o,
  input logic [7:0] pix_g_o,
  input logic [7:0] pix_b_o,
  input logic [7:0] pix_a_o
);
  AST_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o); // R12
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> $stable({pix_r_o, pix_g_o, pix_b_o, pix_a_o})); // R12
  AST_P16_EXPAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && (fmt_i == 3'd0) |->
      (pix_r_o[2:0] == pix_r_o[7:5]) && (pix_g_o[1:0] == pix_g_o[7:6])
      && (pix_b_o[2:0] == pix_b_o[7:5])); // R2
  AST_ALPHA_OPAQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && (fmt_i != 3'd2) && (fmt_i != 3'd3) |-> pix_a_o == 8'hFF); // R11
endmodule

bind pix_unpack pix_unpack_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i),
  .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i),
  .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o), .pix_a_o(pix_a_o)
);

// File: tb/pix_unpack_tb.sv
`timescale 1ns/1ps
module pix_unpack_tb;
  logic clk = 0, rst_ni = 0;
  logic [2:0] fmt = 0;
  logic swap = 0, mtx_en = 0, word_valid = 0, pix_ready = 1;
  logic [3:0] mtx_sel = 0;
  logic [31:0] word = 0;
  logic word_ready, pix_valid;
  logic [7:0] pr, pg, pb, pa;
  int checks = 0, errors = 0, cyc = 0;
  bit stall = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [7:0] bq[$];
  string cur_tag;

  always #2.5 clk = ~clk;

  pix_unpack u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .swap_i(swap), .mtx_en_i(mtx_en),
    .mtx_sel_i(mtx_sel), .word_valid_i(word_valid), .word_i(word),
    .word_ready_o(word_ready), .pix_valid_o(pix_valid), .pix_ready_i(pix_ready),
    .pix_r_o(pr), .pix_g_o(pg), .pix_b_o(pb), .pix_a_o(pa)
  );

  function automatic logic [7:0] clip(input int x);
    int s = x >>> 8;
    if (s < 0) return 8'd0;
    if (s > 255) return 8'd255;
    return s[7:0];
  endfunction

  function automatic logic [31:0] model(input logic [7:0] b0, b1, b2, b3, input bit ph);
    logic [7:0] r, g, b, a, y, u, v, t;
    logic [15:0] hw;
    a = 8'hFF; r = 0; g = 0; b = 0; y = 0; u = 0; v = 0;
    case (fmt)
      3'd1: begin b = b0; g = b1; r = b2; end
      3'd2: begin r = b3; g = b2; b = b1; a = b0; end
      3'd3: begin a = b3; r = b2; g = b1; b = b0; end
      3'd4: begin u = b0; v = b2; y = ph ? b3 : b1; end
      3'd5: begin y = ph ? b2 : b0; u = b1; v = b3; end
      default: begin
        hw = {b1, b0};
        r = {hw[15:11], hw[15:13]};
        g = {hw[10:5], hw[10:9]};
        b = {hw[4:0], hw[4:2]};
      end
    endcase
    if (fmt == 3'd4 || fmt == 3'd5) begin
      if (swap) begin t = u; u = v; v = t; end
      if (mtx_en && mtx_sel == 4'd6) begin
        r = clip(298 * (int'(y) - 16) + 409 * (int'(v) - 128) + 128);
        g = clip(298 * (int'(y) - 16) - 100 * (int'(u) - 128) - 208 * (int'(v) - 128) + 128);
        b = clip(298 * (int'(y) - 16) + 516 * (int'(u) - 128) + 128);
      end else begin
        r = v; g = y; b = u;
      end
    end else if (swap) begin
      t = r; r = b; b = t;
    end
    return {r, g, b, a};
  endfunction

  task automatic expect_pix(input logic [31:0] e);
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  endtask

  // driver: send one word and push the pixels it completes
  task automatic send(input logic [31:0] w);
    int need;
    @(negedge clk);
    word_valid = 1; word = w;
    while (!word_ready) @(negedge clk);
    @(posedge clk);
    for (int i = 0; i < 4; i++) bq.push_back(w[8*i +: 8]);
    need = (fmt == 3'd1) ? 3 : (fmt >= 3'd2 && fmt <= 3'd5) ? 4 : 2;
    while (bq.size() >= need) begin
      logic [7:0] c[4];
      for (int i = 0; i < 4; i++) c[i] = (i < need) ? bq[i] : 8'h00;
      if (fmt == 3'd4 || fmt == 3'd5) begin
        expect_pix(model(c[0], c[1], c[2], c[3], 0));
        expect_pix(model(c[0], c[1], c[2], c[3], 1));
      end else begin
        expect_pix(model(c[0], c[1], c[2], c[3], 0));
      end
      for (int i = 0; i < need; i++) void'(bq.pop_front());
    end
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    word_valid = 0;
    while ((exp_q.size() != 0 || pix_valid) && n < 2000) begin
      @(negedge clk); n++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d pixels missing, expected 0", cur_tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic cfg(input logic [2:0] f, input bit s, input bit me, input logic [3:0] ms, input string t);
    fmt = f; swap = s; mtx_en = me; mtx_sel = ms; cur_tag = t;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && pix_valid && pix_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected pixel %h, expected none", cur_tag, {pr, pg, pb, pa});
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({pr, pg, pb, pa} !== e) begin
          errors++;
          $display("FAIL %s: pixel %h, expected %h", t, {pr, pg, pb, pa}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 pix_ready = stall ? ((cyc % 3) != 0) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks += 2;
    if (pix_valid !== 1'b0) begin errors++; $display("FAIL R1: pix_valid %b, expected 0", pix_valid); end
    if (word_ready !== 1'b1) begin errors++; $display("FAIL R1: word_ready %b, expected 1", word_ready); end
    rst_ni = 1;

    cfg(3'd0, 0, 0, 0, "R2");
    send(32'hF800_07E0); send(32'h1234_ABCD); send(32'hFFFF_0000); drain();
    cfg(3'd0, 1, 0, 0, "R6 565");
    send(32'hF800_001F); send(32'h8421_7BEF); drain();
    cfg(3'd7, 0, 0, 0, "R13");
    send(32'hF800_07E0); send(32'h1234_ABCD); drain();
    cfg(3'd6, 1, 0, 0, "R13 swap");
    send(32'h5A5A_C3C3); drain();

    cfg(3'd1, 0, 0, 0, "R3");
    send(32'h4433_2211); send(32'h8877_6655); send(32'hCCBB_AA99);
    send(32'h0302_0100); send(32'h0706_0504); send(32'h0B0A_0908); drain();
    cfg(3'd1, 1, 0, 0, "R6 888");
    send(32'h4433_2211); send(32'h8877_6655); send(32'hCCBB_AA99); drain();

    cfg(3'd2, 0, 0, 0, "R4");
    send(32'h1122_3344); send(32'hDEAD_BEEF); drain();
    cfg(3'd3, 0, 0, 0, "R5");
    send(32'h1122_3344); send(32'h80FF_0001); drain();
    cfg(3'd3, 1, 0, 0, "R6 argb");
    send(32'h1122_3344); drain();

    cfg(3'd2, 0, 1, 4'd6, "R10 rgba");
    send(32'h1122_3344); drain();
    cfg(3'd0, 0, 1, 4'd6, "R10 565");
    send(32'hF800_07E0); drain();
    cfg(3'd1, 0, 1, 4'd6, "R10 888");
    send(32'h4433_2211); send(32'h8877_6655); send(32'hCCBB_AA99); drain();

    cfg(3'd4, 0, 0, 0, "R7");
    send(32'h4433_2211); send(32'h10F0_2080); drain();
    cfg(3'd5, 0, 0, 0, "R8");
    send(32'h4433_2211); send(32'h10F0_2080); drain();
    cfg(3'd4, 1, 0, 0, "R6 uyvy");
    send(32'h4433_2211); drain();
    cfg(3'd4, 0, 1, 4'd5, "R9 sel");
    send(32'h4433_2211); drain();
    cfg(3'd4, 0, 1, 4'd6, "R9 uyvy");
    send(32'hEB80_1080); send(32'h1000_1000); send(32'hFFFF_FFFF); send(32'h5170_A040); drain();
    cfg(3'd5, 1, 1, 4'd6, "R9 yuyv");
    send(32'h80EB_8010); send(32'h00FF_10FF); send(32'hC830_6090); drain();

    stall = 1;
    cfg(3'd1, 0, 0, 0, "R12 888");
    for (int k = 0; k < 4; k++) begin send(32'h0102_0304 * (k + 1)); send(32'hA5A5_5A5A ^ k); send(32'h0F1E_2D3C + k); end
    drain();
    cfg(3'd5, 0, 1, 4'd6, "R12 yuyv");
    for (int k = 0; k < 6; k++) send(32'h3377_BB11 + 32'h0101_0101 * k);
    drain();
    cfg(3'd0, 0, 0, 0, "R12 565");
    for (int k = 0; k < 6; k++) send(32'h9D3C_64E1 ^ (k << 5));
    drain();
    stall = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule